// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the internal word address for a four-beat memory burst. When either of two start strobes is asserted, it captures the external address and clears its beat index. After that it steps the two least significant address bits through a four-beat sequence, one step per clock in which the active-low advance input is low. While advance is high, the address is held, which inserts wait states.

A static order-select input chooses the beat order. In interleaved order, each beat address is the start value of the low bits XOR the beat index. In linear order, each beat address is the start value plus the beat index, modulo 4. The address bits above the low two come from the captured address and do not change during a burst. After the fourth beat, further advances wrap the sequence back to its start value.

Both outputs are registered. The address and the beat index reflect the inputs of the previous clock edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next value of `addr_out` is 0 and the next value of `beat` is 0.
- R2: If `strb_cpu` or `strb_ctl` is high at an edge, then after that edge `addr_out` equals the `addr_in` sampled at that edge and `beat` is 0.
- R3: With both strobes low and `adv_n` low, `beat` increments by one modulo 4 at the edge.
- R4: With both strobes low and `adv_n` high, `addr_out` and `beat` keep their values.
- R5: With `order_ilv` = 1, `addr_out[1:0]` equals the captured start bits XOR `beat`.
- R6: With `order_ilv` = 0, `addr_out[1:0]` equals the captured start bits plus `beat`, modulo 4.
- R7: Between loads, `addr_out[AW-1:2]` stays equal to the captured `addr_in[AW-1:2]`.
- R8: When a strobe and `adv_n` low occur at the same edge, the load takes effect and the advance is ignored.
- R9: An advance from beat 3 returns `beat` to 0 and `addr_out[1:0]` to the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strb_cpu | input | 1 | Start strobe from the processor side, active high |
| strb_ctl | input | 1 | Start strobe from the controller side, active high |
| adv_n | input | 1 | Advance request, active low; high suspends the burst |
| order_ilv | input | 1 | Order select, static: 1 = interleaved, 0 = linear |
| addr_in | input | AW | External address |
| addr_out | output | AW | Registered internal address |
| beat | output | 2 | Registered beat index, 0 to 3 |

## Verification
The checker monitors several properties on every clock edge:
- capture on either strobe, including the case where advance is also low;
- the modulo-4 beat step and the hold while suspended;
- the reset values and the stability of the upper address bits;
- the step-to-step relation of the low address bits in each order. In interleaved order, the XOR of two successive low-bit values equals the XOR of the two beat indices. In linear order, the low bits move up by one.

The checker cannot see the absolute start value, so only the bench scenarios show it. These scenarios cover the exact sequences from given start values, the return to the start value after the fourth beat, and long random mixes of strobes and suspends compared against an independent model.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEATS = 4;
  localparam int BW    = $clog2(BEATS);
  typedef logic [BW-1:0] beat_t;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} order_e;
endpackage

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  step,
  output beat_t beat_q,
  output beat_t beat_nxt
);
  always_comb begin
    if (load)      beat_nxt = '0;
    else if (step) beat_nxt = beat_q + beat_t'(1);
    else           beat_nxt = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_nxt;
  end
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import burst_seq_pkg::*;
(
  input  order_e order,
  input  beat_t  start,
  input  beat_t  beat,
  output beat_t  low
);
  beat_t xor_low;
  beat_t add_low;

  for (genvar b = 0; b < BW; b++) begin : g_xor
    assign xor_low[b] = start[b] ^ beat[b];
  end

  assign add_low = start + beat;
  assign low     = (order == ORD_INTERLEAVE) ? xor_low : add_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strb_cpu,
  input  logic          strb_ctl,
  input  logic          adv_n,
  input  logic          order_ilv,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic [1:0]    beat
);
  localparam int HW = AW - BW;

  logic          load;
  logic [AW-1:0] base_q;
  logic [AW-1:0] base_nxt;
  beat_t         beat_q;
  beat_t         beat_nxt;
  beat_t         low_nxt;
  order_e        order;

  assign load     = strb_cpu | strb_ctl;
  assign base_nxt = load ? addr_in : base_q;
  assign order    = order_ilv ? ORD_INTERLEAVE : ORD_LINEAR;

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else     base_q <= base_nxt;
  end

  bseq_beat_ctr u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (~adv_n),
    .beat_q   (beat_q),
    .beat_nxt (beat_nxt)
  );

  bseq_order_map u_map (
    .order (order),
    .start (base_nxt[BW-1:0]),
    .beat  (beat_nxt),
    .low   (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_out <= '0;
    else     addr_out <= {base_nxt[AW-1:BW], low_nxt};
  end

  assign beat = beat_q;

  logic [HW-1:0] unused_hw;
  assign unused_hw = '0;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          strb_cpu,
  input logic          strb_ctl,
  input logic          adv_n,
  input logic          order_ilv,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out,
  input logic [1:0]    beat
);
  logic ld;
  assign ld = strb_cpu | strb_ctl;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (addr_out == '0 && beat == 2'd0)); // R1
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ld |=> (addr_out == $past(addr_in) && beat == 2'd0)); // R2
  AST_LOAD_OVER_ADV: assert property (@(posedge clk) disable iff (rst)
    (ld && !adv_n) |=> beat == 2'd0); // R8
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ld && !adv_n) |=> beat == $past(beat) + 2'd1); // R3
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ld && adv_n) |=> ($stable(addr_out) && $stable(beat))); // R4
  AST_ILV_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ld && !adv_n && order_ilv) |=>
      ((addr_out[1:0] ^ $past(addr_out[1:0])) == (beat ^ $past(beat)))); // R5
  AST_LIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ld && !adv_n && !order_ilv) |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1); // R6
  AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (rst)
    !ld |=> addr_out[AW-1:2] == $past(addr_out[AW-1:2])); // R7
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .strb_cpu  (strb_cpu),
  .strb_ctl  (strb_ctl),
  .adv_n     (adv_n),
  .order_ilv (order_ilv),
  .addr_in   (addr_in),
  .addr_out  (addr_out),
  .beat      (beat)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strb_cpu = 1'b0;
  logic          strb_ctl = 1'b0;
  logic          adv_n = 1'b1;
  logic          order_ilv = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat;

  int n_chk = 0;
  int n_bad = 0;

  logic [AW-1:0] m_base;
  logic [1:0]    m_beat;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) i_burst_addr_seq (
    .clk(clk), .rst(rst), .strb_cpu(strb_cpu), .strb_ctl(strb_ctl),
    .adv_n(adv_n), .order_ilv(order_ilv), .addr_in(addr_in),
    .addr_out(addr_out), .beat(beat)
  );

  function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] k,
                                         input logic ilv);
    logic [1:0] r;
    if (ilv) r = {s[1] ^ k[1], s[0] ^ k[0]};
    else     r = 2'((int'(s) + int'(k)) % 4);
    return r;
  endfunction

  function automatic logic [AW-1:0] exp_addr();
    return {m_base[AW-1:2], exp_low(m_base[1:0], m_beat, order_ilv)};
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] ea, input logic [1:0] eb);
    n_chk++;
    if (addr_out !== ea || beat !== eb) begin
      n_bad++;
      $display("FAIL %s: addr_out=%h beat=%0d expected addr_out=%h beat=%0d",
               tag, addr_out, beat, ea, eb);
    end
  endtask

  task automatic step(input logic sc, input logic st, input logic an,
                      input logic [AW-1:0] a);
    strb_cpu = sc; strb_ctl = st; adv_n = an; addr_in = a;
    @(negedge clk);
    if (sc || st) begin m_base = a; m_beat = 2'd0; end
    else if (!an) m_beat = m_beat + 2'd1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    strb_cpu = 1'b0; strb_ctl = 1'b0; adv_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_base = '0; m_beat = 2'd0;
  endtask

  task automatic seq4(input string tag, input logic [AW-1:0] a, input logic ilv,
                      input logic [1:0] l0, input logic [1:0] l1,
                      input logic [1:0] l2, input logic [1:0] l3);
    logic [1:0] exp_seq [4];
    exp_seq[0] = l0; exp_seq[1] = l1; exp_seq[2] = l2; exp_seq[3] = l3;
    order_ilv = ilv;
    step(1'b1, 1'b0, 1'b1, a);
    check({tag, " beat0"}, {a[AW-1:2], exp_seq[0]}, 2'd0);
    for (int i = 1; i < 4; i++) begin
      step(1'b0, 1'b0, 1'b0, 16'h0000);
      check(tag, {a[AW-1:2], exp_seq[i]}, 2'(i));
    end
    step(1'b0, 1'b0, 1'b0, 16'h0000);
    check("R9 wrap to start", {a[AW-1:2], exp_seq[0]}, 2'd0);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    addr_in = 16'hFFFF;
    do_reset();
    check("R1 reset state", '0, 2'd0);

    seq4("R5 ilv start 01", 16'hA5C1, 1'b1, 2'b01, 2'b00, 2'b11, 2'b10);
    seq4("R5 ilv start 10", 16'h1232, 1'b1, 2'b10, 2'b11, 2'b00, 2'b01);
    seq4("R6 lin start 11", 16'h7F03, 1'b0, 2'b11, 2'b00, 2'b01, 2'b10);
    seq4("R6 lin start 01", 16'h0005, 1'b0, 2'b01, 2'b10, 2'b11, 2'b00);

    order_ilv = 1'b1;
    do_reset();
    step(1'b0, 1'b1, 1'b1, 16'hBEE2);
    check("R2 load via strb_ctl", 16'hBEE2, 2'd0);
    step(1'b0, 1'b0, 1'b0, 16'h1111);
    check("R7 upper bits ignore addr_in", 16'hBEE3, 2'd1);
    step(1'b0, 1'b0, 1'b1, 16'h2222);
    check("R4 suspend hold", 16'hBEE3, 2'd1);
    step(1'b0, 1'b0, 1'b1, 16'h3333);
    check("R4 suspend hold again", 16'hBEE3, 2'd1);
    step(1'b1, 1'b0, 1'b0, 16'h4443);
    check("R8 load beats advance", 16'h4443, 2'd0);
    step(1'b0, 1'b0, 1'b0, 16'h0000);
    check("R3 step after load", 16'h4442, 2'd1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid burst", '0, 2'd0);
    rst = 1'b0;
    m_base = '0; m_beat = 2'd0;

    for (int pass = 0; pass < 2; pass++) begin
      order_ilv = (pass == 0);
      do_reset();
      for (int i = 0; i < 600; i++) begin
        logic [3:0] r;
        r = 4'($urandom);
        step(r == 4'd0, r == 4'd1, r[3], 16'($urandom));
        check(order_ilv ? "R5 R3 R4 random ilv" : "R6 R3 R4 random lin",
              exp_addr(), m_beat);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule